// File: doc/BRIEF.md
# Display Command Sequencer

This block sits behind the host interface of a small character-and-icon LCD controller. Each accepted byte is tagged as either a command or display data. The block decodes it, keeps the display address pointer, and issues write strobes toward an external 64-entry display RAM and an external icon blink-mask RAM. It also holds the mode registers that the scan block reads: display enable, icon-only view, blink pattern, contrast stage, and the per-address character blink flags.

Valid RAM addresses fall in four windows of twelve: 0-11, 16-27, 32-43 and 48-59. The pointer only ever holds one of these addresses. When it advances past the end of a window it jumps to the start of the next window, and after 59 it returns to 0. An increment command can also have a side effect on the address it leaves: writing a blank code, clearing the blink flag, or both. The contrast counter has three bits and wraps in both directions. A two-bit offset from pins is added to it to form the reported stage. A stop command puts the block into standby. In standby, only bytes with bit 0 set are accepted, and such a byte also ends standby.

Top module: `glyph_cmd_seq`

## Requirements
- R1: Command 11AAAAAA loads the pointer with A[5:0]. If A[3:0] is 12 to 15, the pointer becomes 0 instead. The pointer never leaves the windows 0-11, 16-27, 32-43 and 48-59.
- R2: A pointer step moves 11 to 16, 27 to 32, 43 to 48 and 59 to 0. From any other address it adds one.
- R3: The pointer steps after a data byte, after the increment command 100x101x and after the character-blink command 000x01Bx. Every other command leaves the pointer unchanged, except load (R1) and stop (R8).
- R4: Command 1011xxII stores a two-bit option. When option bit 0 is set, each increment command writes BLANK (default 8'h20) to the current address before the step. When option bit 1 is set, each increment command clears that address's blink flag. Both bits can act together.
- R5: Command 100x001D adds one to the 3-bit contrast counter when D=1 and subtracts one when D=0, wrapping 7 to 0 and 0 to 7. contrast_stage equals the counter plus stage_offs and appears one cycle after the change.
- R6: Command 100x110D sets icon-blink mode from D. In this mode a data byte pulses mask_we at the current address if the address is 32 or above. At any lower address the byte writes nothing. The pointer steps in both cases. ram_we and mask_we are never high together.
- R7: Command 000x01Bx sets char_blink[pointer] to B.
- R8: Command 100x0100 enters standby, clears disp_on and icon_only, and sets the pointer to 0. In standby, a byte with bit 0 clear has no effect. A byte with bit 0 set leaves standby and is executed as usual, whether it is a command or data.
- R9: Command 100E100D sets disp_on from D and icon_only from E. Command 100x111D sets blink_all_on from D.
- R10: Reset (active-high, synchronous) sets the pointer, option, counter, char_blink and all mode outputs to 0 and issues no RAM or mask write. Data already in the RAMs is left as it is.
- R11: A data write pulses ram_we for one cycle with ram_addr at the current pointer and ram_wdata equal to the byte. The pulse comes one cycle after the byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One accepted byte this cycle |
| in_cmd | input | 1 | 1 = command, 0 = display data |
| in_byte | input | 8 | Byte value |
| stage_offs | input | 2 | Contrast stage offset from pins |
| ram_we | output | 1 | Display RAM write strobe |
| mask_we | output | 1 | Icon blink-mask RAM write strobe |
| ram_addr | output | 6 | Address for either strobe |
| ram_wdata | output | 8 | Write data for either strobe |
| char_blink | output | 64 | Character blink flag per address |
| addr_ptr | output | 6 | Current address pointer |
| disp_on | output | 1 | Display enabled |
| icon_only | output | 1 | Show icons only |
| blink_all_on | output | 1 | Blink phase lights all dots (else blanks) |
| icon_blk_mode | output | 1 | Data bytes go to blink masks |
| standby | output | 1 | Standby active |
| contrast_stage | output | 4 | Counter plus offset |

## Verification
The assertions check on every cycle the following:
- the pointer stays inside its windows;
- the two strobes never overlap;
- mask writes stay in the icon region;
- the contrast counter moves by exactly one step per command;
- the blink flags change at most one bit per cycle;
- standby holds back any strobe for a byte whose bit 0 is clear, and entering standby zeroes the pointer.

Only the bench scenarios can show the following:
- the exact step order across window edges and the wrap at 59;
- the snapping of invalid load values;
- which data value and address each write carries;
- the order in which the increment options act;
- that a waking byte is also executed;
- the reset values.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_DATA, OP_LDPTR, OP_OPT, OP_CONT, OP_STOP,
    OP_DISP, OP_INC, OP_ICON, OP_PAT, OP_CHB
  } op_e;
endpackage

// File: rtl/gcs_ptr.sv
module gcs_ptr #(
  parameter int ADDR_W   = 6,
  parameter int GRP_W    = 4,
  parameter int GRP_USED = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - GRP_W;
  localparam logic [GRP_W-1:0] LAST = GRP_W'(GRP_USED - 1);

  logic [ADDR_W-1:0] ptr_q, step_val, snap_val;

  always_comb begin
    if (ptr_q[GRP_W-1:0] == LAST)
      step_val = {ptr_q[ADDR_W-1:GRP_W] + HI_W'(1), {GRP_W{1'b0}}};
    else
      step_val = ptr_q + ADDR_W'(1);
    snap_val = (load_val[GRP_W-1:0] > LAST) ? '0 : load_val;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (clr)  ptr_q <= '0;
    else if (load) ptr_q <= snap_val;
    else if (step) ptr_q <= step_val;
  end

  assign ptr = ptr_q;

  // R1 R2: pointer never sits in an unused slot of a window
  p_in_window_r1: assert property (@(posedge clk) disable iff (rst)
    ptr_q[GRP_W-1:0] <= LAST);
  // R2: a lone step always moves the pointer
  p_step_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr) |=> ptr_q != $past(ptr_q));
endmodule

// File: rtl/gcs_contrast.sv
module gcs_contrast #(
  parameter int CNT_W  = 3,
  parameter int OFFS_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up,
  input  logic               dn,
  input  logic [OFFS_W-1:0]  offs,
  output logic [CNT_W:0]     stage
);
  localparam int STAGE_W = CNT_W + 1;

  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [STAGE_W-1:0] stage_q;

  always_comb begin
    cnt_n = cnt_q;
    if (up)      cnt_n = cnt_q + CNT_W'(1);
    else if (dn) cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      cnt_q   <= cnt_n;
      stage_q <= STAGE_W'(cnt_n) + STAGE_W'(offs);
    end
  end

  assign stage = stage_q;

  p_cnt_up_r5: assert property (@(posedge clk) disable iff (rst)
    up |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_cnt_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (dn && !up) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!up && !dn) |=> $stable(cnt_q));
endmodule

// File: rtl/gcs_flags.sv
module gcs_flags #(
  parameter int ADDR_W = 6,
  localparam int N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_val,
  output logic [N-1:0]      flags
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                        flag_q[i] <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(i))        flag_q[i] <= wr_val;
    end
  end

  assign flags = flag_q;

  // R7: at most one flag changes per cycle
  p_one_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(flag_q ^ $past(flag_q)) <= 1);
  p_flag_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flag_q));
endmodule

// File: rtl/glyph_cmd_seq.sv
module glyph_cmd_seq
  import gcs_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 6,
  parameter int          GRP_W    = 4,
  parameter int          GRP_USED = 12,
  parameter int          CNT_W    = 3,
  parameter int          OFFS_W   = 2,
  parameter logic [7:0]  BLANK    = 8'h20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_cmd,
  input  logic [DATA_W-1:0]       in_byte,
  input  logic [OFFS_W-1:0]       stage_offs,
  output logic                    ram_we,
  output logic                    mask_we,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic [DATA_W-1:0]       ram_wdata,
  output logic [(1<<ADDR_W)-1:0]  char_blink,
  output logic [ADDR_W-1:0]       addr_ptr,
  output logic                    disp_on,
  output logic                    icon_only,
  output logic                    blink_all_on,
  output logic                    icon_blk_mode,
  output logic                    standby,
  output logic [CNT_W:0]          contrast_stage
);
  op_e              op, act;
  logic             accept;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]       opt_q;
  logic             data_wr, mask_wr, blank_wr, flag_we, flag_val;
  logic             ram_we_q, mask_we_q, disp_q, ionly_q, pat_q, icon_q, stby_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // opcode classification
  always_comb begin
    op = OP_NONE;
    if (!in_cmd)                          op = OP_DATA;
    else if (in_byte[7:6] == 2'b11)       op = OP_LDPTR;
    else if (in_byte[7:4] == 4'b1011)     op = OP_OPT;
    else if (in_byte[7:5] == 3'b100) begin
      casez (in_byte[3:0])
        4'b001?: op = OP_CONT;
        4'b0100: op = OP_STOP;
        4'b100?: op = OP_DISP;
        4'b101?: op = OP_INC;
        4'b110?: op = OP_ICON;
        4'b111?: op = OP_PAT;
        default: op = OP_NONE;
      endcase
    end else if (in_byte[7:5] == 3'b000 && in_byte[3:2] == 2'b01)
      op = OP_CHB;
  end

  // standby gate: only bytes with bit 0 set get through
  assign accept = in_valid && (!stby_q || in_byte[0]);
  assign act    = accept ? op : OP_NONE;

  assign data_wr  = (act == OP_DATA) && !icon_q;
  assign mask_wr  = (act == OP_DATA) && icon_q && ptr[ADDR_W-1];
  assign blank_wr = (act == OP_INC) && opt_q[0];
  assign flag_we  = (act == OP_CHB) || ((act == OP_INC) && opt_q[1]);
  assign flag_val = (act == OP_CHB) ? in_byte[1] : 1'b0;

  gcs_ptr #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .GRP_USED(GRP_USED)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .clr      (act == OP_STOP),
    .load     (act == OP_LDPTR),
    .load_val (in_byte[ADDR_W-1:0]),
    .step     ((act == OP_DATA) || (act == OP_INC) || (act == OP_CHB)),
    .ptr      (ptr)
  );

  gcs_contrast #(.CNT_W(CNT_W), .OFFS_W(OFFS_W)) u_cont (
    .clk   (clk),
    .rst   (rst),
    .up    ((act == OP_CONT) && in_byte[0]),
    .dn    ((act == OP_CONT) && !in_byte[0]),
    .offs  (stage_offs),
    .stage (contrast_stage)
  );

  gcs_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (flag_we),
    .wr_addr (ptr),
    .wr_val  (flag_val),
    .flags   (char_blink)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we_q  <= 1'b0;
      mask_we_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      opt_q     <= '0;
      disp_q    <= 1'b0;
      ionly_q   <= 1'b0;
      pat_q     <= 1'b0;
      icon_q    <= 1'b0;
      stby_q    <= 1'b0;
    end else begin
      ram_we_q  <= data_wr || blank_wr;
      mask_we_q <= mask_wr;
      addr_q    <= ptr;
      wdata_q   <= blank_wr ? BLANK : in_byte;
      if (accept) stby_q <= 1'b0;
      unique case (act)
        OP_OPT:  opt_q  <= in_byte[1:0];
        OP_ICON: icon_q <= in_byte[0];
        OP_PAT:  pat_q  <= in_byte[0];
        OP_DISP: begin
          disp_q  <= in_byte[0];
          ionly_q <= in_byte[4];
        end
        OP_STOP: begin
          stby_q  <= 1'b1;
          disp_q  <= 1'b0;
          ionly_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ram_we        = ram_we_q;
  assign mask_we       = mask_we_q;
  assign ram_addr      = addr_q;
  assign ram_wdata     = wdata_q;
  assign addr_ptr      = ptr;
  assign disp_on       = disp_q;
  assign icon_only     = ionly_q;
  assign blink_all_on  = pat_q;
  assign icon_blk_mode = icon_q;
  assign standby       = stby_q;

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && mask_we));
  p_mask_icon_r6: assert property (@(posedge clk) disable iff (rst)
    mask_we |-> ram_addr[ADDR_W-1]);
  p_standby_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (standby && in_valid && !in_byte[0]) |=> (!ram_we && !mask_we && $stable(addr_ptr)));
  p_stop_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(standby) |-> (addr_ptr == '0 && !disp_on));
  p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !$past(in_valid)) |-> 1'b0);
endmodule

// File: tb/glyph_cmd_seq_tb.sv
module glyph_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_cmd = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [1:0]  stage_offs = 2'd2;
  logic        ram_we, mask_we, disp_on, icon_only, blink_all_on, icon_blk_mode, standby;
  logic [5:0]  ram_addr, addr_ptr;
  logic [7:0]  ram_wdata;
  logic [63:0] char_blink;
  logic [3:0]  contrast_stage;

  int checks = 0;
  int errors = 0;

  // expected writes: {mask, addr, data}
  logic [14:0] exp_q[$];

  // bench model
  logic [5:0]  m_ptr;
  logic [1:0]  m_opt;
  logic [2:0]  m_cnt;
  logic [63:0] m_flags;
  logic        m_disp, m_ionly, m_pat, m_icon, m_stby;

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_cmd_seq u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cmd(in_cmd), .in_byte(in_byte),
    .stage_offs(stage_offs), .ram_we(ram_we), .mask_we(mask_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .char_blink(char_blink), .addr_ptr(addr_ptr),
    .disp_on(disp_on), .icon_only(icon_only), .blink_all_on(blink_all_on),
    .icon_blk_mode(icon_blk_mode), .standby(standby), .contrast_stage(contrast_stage)
  );

  function automatic logic [5:0] after(input logic [5:0] p);
    case (p)
      6'd11:   return 6'd16;
      6'd27:   return 6'd32;
      6'd43:   return 6'd48;
      6'd59:   return 6'd0;
      default: return p + 6'd1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = '0; m_opt = '0; m_cnt = '0; m_flags = '0;
    m_disp = 0; m_ionly = 0; m_pat = 0; m_icon = 0; m_stby = 0;
  endtask

  task automatic check_state(input string tag);
    logic [3:0] st;
    st = 4'(m_cnt) + 4'(stage_offs);
    chk(addr_ptr == m_ptr, tag, "ptr", 64'(addr_ptr), 64'(m_ptr));
    chk(char_blink == m_flags, tag, "flags", char_blink, m_flags);
    chk({disp_on, icon_only, blink_all_on, icon_blk_mode, standby} ==
        {m_disp, m_ionly, m_pat, m_icon, m_stby}, tag, "modes",
        64'({disp_on, icon_only, blink_all_on, icon_blk_mode, standby}),
        64'({m_disp, m_ionly, m_pat, m_icon, m_stby}));
    chk(contrast_stage == st, tag, "stage", 64'(contrast_stage), 64'(st));
  endtask

  // driver: update model, queue expected writes, drive one byte
  task automatic send(input logic c, input logic [7:0] b, input string tag);
    if (!m_stby || b[0]) begin
      m_stby = 0;
      if (!c) begin
        if (!m_icon) exp_q.push_back({1'b0, m_ptr, b});
        else if (m_ptr >= 6'd32) exp_q.push_back({1'b1, m_ptr, b});
        m_ptr = after(m_ptr);
      end else begin
        casez (b)
          8'b11??????: m_ptr = (b[3:0] >= 4'd12) ? 6'd0 : b[5:0];
          8'b1011????: m_opt = b[1:0];
          8'b100?001?: m_cnt = b[0] ? m_cnt + 3'd1 : m_cnt - 3'd1;
          8'b100?0100: begin m_stby = 1; m_disp = 0; m_ionly = 0; m_ptr = 0; end
          8'b100?100?: begin m_disp = b[0]; m_ionly = b[4]; end
          8'b100?101?: begin
            if (m_opt[0]) exp_q.push_back({1'b0, m_ptr, 8'h20});
            if (m_opt[1]) m_flags[m_ptr] = 1'b0;
            m_ptr = after(m_ptr);
          end
          8'b100?110?: m_icon = b[0];
          8'b100?111?: m_pat = b[0];
          8'b000?01??: begin m_flags[m_ptr] = b[1]; m_ptr = after(m_ptr); end
          default: ;
        endcase
      end
    end
    @(negedge clk);
    in_valid = 1'b1; in_cmd = c; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
    check_state(tag);
  endtask

  // monitor: compare each strobe with the front of the queue
  always @(negedge clk) begin
    if (!rst && (ram_we || mask_we)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 R6 unexpected write actual=%0h expected=none",
                 {mask_we, ram_addr, ram_wdata});
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        if ({mask_we, ram_addr, ram_wdata} !== e || (ram_we && mask_we)) begin
          errors++;
          $display("FAIL R11 R4 R6 write actual=%0h expected=%0h",
                   {mask_we, ram_addr, ram_wdata}, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state
    check_state("R10");
    chk(!ram_we && !mask_we, "R10", "strobes", 64'({ram_we, mask_we}), 64'(0));

    // R11 plain data writes, R2 window crossing
    send(1'b0, 8'h41, "R11");
    send(1'b1, 8'hCA, "R1");          // load 10
    for (int i = 0; i < 4; i++) send(1'b0, 8'h50 + 8'(i), "R2");  // 10,11,16,17
    send(1'b1, 8'hDB, "R1");          // 27
    send(1'b0, 8'h60, "R2");          // -> 32
    send(1'b1, 8'hFB, "R1");          // 59
    send(1'b0, 8'h61, "R2");          // -> 0
    // R1 snapping
    send(1'b1, 8'hCD, "R1");          // 13 -> 0
    send(1'b1, 8'hE5, "R1");          // 37
    send(1'b1, 8'hFC, "R1");          // 60 -> 0
    send(1'b1, 8'hEB, "R1");          // 43
    send(1'b1, 8'h9A, "R3");          // increment, no option -> 48

    // R3 commands that do not move the pointer
    send(1'b1, 8'hB0, "R3");
    send(1'b1, 8'h9E, "R3");
    send(1'b1, 8'h9C, "R3");
    send(1'b1, 8'h80, "R3");

    // R7 character blink set and clear
    send(1'b1, 8'hC3, "R1");          // 3
    send(1'b1, 8'h06, "R7");          // flag 3 =1, ->4
    send(1'b1, 8'h06, "R7");          // flag 4 =1, ->5
    send(1'b1, 8'h04, "R7");          // flag 5 =0, ->6

    // R4 options
    send(1'b1, 8'hC3, "R1");
    send(1'b1, 8'hB1, "R4");          // blank only
    send(1'b1, 8'h9A, "R4");          // blank at 3, flag 3 kept
    send(1'b1, 8'hB2, "R4");          // clear only
    send(1'b1, 8'h9B, "R4");          // clear flag 4, no write
    send(1'b1, 8'hC9, "R1");          // 9
    send(1'b1, 8'h06, "R7");
    send(1'b1, 8'hC9, "R1");
    send(1'b1, 8'hB3, "R4");          // both
    send(1'b1, 8'h9A, "R4");
    send(1'b1, 8'hB0, "R4");

    // R5 contrast wrap, offset change
    for (int i = 0; i < 8; i++) send(1'b1, 8'h83, "R5");
    send(1'b1, 8'h82, "R5");          // 0 -> 7
    stage_offs = 2'd3;
    @(negedge clk); @(negedge clk);
    check_state("R5");                // 7 + 3 = 10
    send(1'b1, 8'h93, "R5");          // 7 -> 0

    // R6 icon blink routing
    send(1'b1, 8'h8D, "R6");
    send(1'b1, 8'hE1, "R1");          // 33
    send(1'b0, 8'h15, "R6");
    send(1'b1, 8'hC5, "R1");          // 5
    send(1'b0, 8'h1F, "R6");          // ignored, ptr -> 6
    send(1'b1, 8'h8C, "R6");

    // R9 display and pattern
    send(1'b1, 8'h99, "R9");
    send(1'b1, 8'h89, "R9");
    send(1'b1, 8'h8F, "R9");
    send(1'b1, 8'h88, "R9");
    send(1'b1, 8'h89, "R9");

    // R8 standby
    send(1'b1, 8'hE5, "R1");
    send(1'b1, 8'h94, "R8");
    send(1'b0, 8'h42, "R8");          // ignored
    send(1'b1, 8'hC4, "R8");          // ignored (bit0 clear)
    send(1'b1, 8'h82, "R8");          // ignored
    send(1'b0, 8'h43, "R8");          // wakes and writes at 0
    send(1'b1, 8'h84, "R8");
    send(1'b1, 8'hC5, "R8");          // wakes, loads 5

    // R10 reset mid-run clears modes
    send(1'b1, 8'h83, "R5");
    send(1'b1, 8'hB3, "R4");
    send(1'b1, 8'h8D, "R6");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    @(negedge clk);
    check_state("R10");
    chk(!ram_we && !mask_we, "R10", "strobes", 64'({ram_we, mask_we}), 64'(0));
    send(1'b1, 8'h9A, "R10");         // option cleared: no blank write

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "pending writes", 64'(exp_q.size()), 64'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule